// File: doc/BRIEF.md
# SIMT Warp Reconvergence Stack

This block tracks control-flow divergence for one warp of a SIMT core. It holds a small stack of entries. Each entry has a next-instruction PC, a reconvergence PC and a thread mask. Only the top entry drives the warp: its PC and mask go to fetch and scheduling. For every branch, the core supplies the taken target, the fall-through address, the per-thread taken bits and the immediate postdominator. The block then either moves the top PC or splits the warp into path entries.

When a split happens, the top entry is parked at the reconvergence point. The not-taken group and then the taken group are pushed above it in one cycle. A path whose first PC already equals the reconvergence point is not pushed, so a divergent loop exit adds only one entry. When the top entry's PC arrives at its reconvergence PC, the block spends one cycle popping it, and the entry below resumes. The bottom entry has an all-ones reconvergence PC, which acts as a sentinel meaning "never reconverge". Warp width, stack depth, PC width and the sequential PC step are parameters.

Top module: `simt_reconv_stack`

## Requirements
- R1: After reset the stack holds one entry: PC RESET_PC, mask all ones, reconvergence PC all ones, depth 1, and both flags low. A `launch` pulse restores the same single-entry state with PC `launch_pc` and mask `launch_mask`, and clears both flags.
- R2: An accepted non-branch instruction adds PC_INC to the top PC and leaves the depth unchanged.
- R3: An accepted branch where no active thread is split changes only the top PC and pushes nothing. The top PC goes to `br_target` when no active thread is not-taken, and to `br_fallthru` when no active thread is taken.
- R4: An accepted branch that splits the active threads does three things in one cycle. It rewrites the top PC to `br_rpc`. It pushes a not-taken entry (PC `br_fallthru`). It then pushes a taken entry (PC `br_target`) above that. The taken entry becomes the new top with the taken threads as its mask, and both pushed entries carry `br_rpc`.
- R5: A path whose PC equals `br_rpc` is not pushed. A divergent loop exit therefore grows the stack by exactly one entry.
- R6: `issue_en` is low exactly when the top PC equals the top reconvergence PC and the depth exceeds 1. In that cycle the instruction inputs are ignored and the top entry is popped. The entry below appears on the outputs with its stored PC and mask.
- R7: When the entry exposed by a pop is itself at its reconvergence PC, it is popped in the next cycle. Pops happen at most one per cycle.
- R8: A split that needs more entries than DEPTH leaves the whole stack unchanged and sets `overflow`. The flag stays set until `launch`.
- R9: When the single remaining entry's PC reaches the all-ones sentinel, the entry is not popped. The depth stays 1, `issue_en` stays high and `underflow` is set until `launch`.
- R10: Bits of `br_taken` that belong to threads outside the top mask have no effect. Only the top mask ANDed with `br_taken` (taken) and the top mask ANDed with its complement (not-taken) count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| launch | input | 1 | Start a warp: reset stack to one entry |
| launch_pc | input | PCW | Start PC for a launch |
| launch_mask | input | WARP | Active threads for a launch |
| instr_valid | input | 1 | An instruction of the top entry completes this cycle |
| is_branch | input | 1 | That instruction is a branch |
| br_target | input | PCW | Taken destination |
| br_fallthru | input | PCW | Not-taken destination |
| br_taken | input | WARP | Per-thread taken outcome |
| br_rpc | input | PCW | Reconvergence PC (immediate postdominator) |
| top_pc | output | PCW | PC of the top entry |
| top_mask | output | WARP | Active mask of the top entry |
| issue_en | output | 1 | Top entry may issue (low during a pop cycle) |
| stack_depth | output | $clog2(DEPTH+1) | Number of valid entries |
| overflow | output | 1 | Sticky: a split was refused for lack of room |
| underflow | output | 1 | Sticky: the sentinel entry reached the sentinel PC |

## Verification
Corrupted stack contents stay hidden until that entry comes back to the top. A wrong mask or PC stored in a pushed not-taken entry shows only after the taken path has run to the reconvergence point and been popped. The bench therefore drives every split all the way through both paths and back to the full mask. A wrong depth count or pop condition shows within one cycle as a missing or extra `issue_en` bubble. Flag errors show on the cycle after the refused split or the sentinel hit.

// File: rtl/simt_reconv_stack.sv
module simt_reconv_stack #(
  parameter int WARP     = 4,
  parameter int DEPTH    = 8,
  parameter int PCW      = 16,
  parameter int PC_INC   = 1,
  parameter logic [PCW-1:0] RESET_PC = '0,
  localparam int DW = $clog2(DEPTH + 1),
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            launch,
  input  logic [PCW-1:0]  launch_pc,
  input  logic [WARP-1:0] launch_mask,
  input  logic            instr_valid,
  input  logic            is_branch,
  input  logic [PCW-1:0]  br_target,
  input  logic [PCW-1:0]  br_fallthru,
  input  logic [WARP-1:0] br_taken,
  input  logic [PCW-1:0]  br_rpc,
  output logic [PCW-1:0]  top_pc,
  output logic [WARP-1:0] top_mask,
  output logic            issue_en,
  output logic [DW-1:0]   stack_depth,
  output logic            overflow,
  output logic            underflow
);
  localparam logic [PCW-1:0] NO_RPC = '1;

  logic [PCW-1:0]  pc_q  [DEPTH];
  logic [PCW-1:0]  rpc_q [DEPTH];
  logic [WARP-1:0] msk_q [DEPTH];
  logic [DW-1:0]   cnt_q;
  logic            ovf_q, udf_q;

  logic [AW-1:0]   ti;
  logic [PCW-1:0]  cur_rpc, nxt_pc;
  logic [WARP-1:0] tk, nt;
  logic            at_rpc, pop_req, accept, diverge, push_nt, push_tk, no_room;
  logic [1:0]      n_push;

  assign ti       = AW'(cnt_q - DW'(1));
  assign top_pc   = pc_q[ti];
  assign top_mask = msk_q[ti];
  assign cur_rpc  = rpc_q[ti];

  assign at_rpc   = top_pc == cur_rpc;
  assign pop_req  = at_rpc && (cnt_q > DW'(1));
  assign issue_en = !pop_req;
  assign accept   = instr_valid && issue_en && !launch;

  assign tk       = br_taken & top_mask;
  assign nt       = top_mask & ~br_taken;
  assign diverge  = accept && is_branch && (|tk) && (|nt);
  assign push_nt  = diverge && (br_fallthru != br_rpc);
  assign push_tk  = diverge && (br_target != br_rpc);
  assign n_push   = {1'b0, push_nt} + {1'b0, push_tk};
  assign no_room  = diverge && (int'(cnt_q) + int'(n_push) > DEPTH);

  always_comb begin
    if (!is_branch)     nxt_pc = top_pc + PCW'(PC_INC);
    else if (nt == '0)  nxt_pc = br_target;
    else if (tk == '0)  nxt_pc = br_fallthru;
    else                nxt_pc = br_rpc;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || launch) begin
      cnt_q <= DW'(1);
      ovf_q <= 1'b0;
      udf_q <= 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
        pc_q[i]  <= '0;
        rpc_q[i] <= NO_RPC;
        msk_q[i] <= '0;
      end
      pc_q[0]  <= rst_n ? launch_pc : RESET_PC;
      msk_q[0] <= rst_n ? launch_mask : '1;
    end else begin
      if (cnt_q == DW'(1) && at_rpc) udf_q <= 1'b1;
      if (pop_req) begin
        cnt_q <= cnt_q - DW'(1);
      end else if (no_room) begin
        ovf_q <= 1'b1;
      end else if (accept) begin
        pc_q[ti] <= nxt_pc;
        for (int i = 0; i < DEPTH; i++) begin
          if (push_nt && i == int'(ti) + 1) begin
            pc_q[i]  <= br_fallthru;
            rpc_q[i] <= br_rpc;
            msk_q[i] <= nt;
          end
          if (push_tk && i == int'(ti) + 1 + int'(push_nt)) begin
            pc_q[i]  <= br_target;
            rpc_q[i] <= br_rpc;
            msk_q[i] <= tk;
          end
        end
        cnt_q <= cnt_q + DW'(n_push);
      end
    end
  end

  assign stack_depth = cnt_q;
  assign overflow    = ovf_q;
  assign underflow   = udf_q;
endmodule

// File: rtl/simt_reconv_stack_chk.sv
module simt_reconv_stack_chk #(
  parameter int WARP   = 4,
  parameter int DEPTH  = 8,
  parameter int PCW    = 16,
  parameter int PC_INC = 1,
  localparam int DW = $clog2(DEPTH + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            launch,
  input logic [PCW-1:0]  launch_pc,
  input logic [WARP-1:0] launch_mask,
  input logic            instr_valid,
  input logic            is_branch,
  input logic [PCW-1:0]  br_target,
  input logic [WARP-1:0] br_taken,
  input logic [PCW-1:0]  top_pc,
  input logic [WARP-1:0] top_mask,
  input logic            issue_en,
  input logic [DW-1:0]   stack_depth,
  input logic            overflow,
  input logic            underflow
);
  assert_launch_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> stack_depth == DW'(1) && top_pc == $past(launch_pc) &&
               top_mask == $past(launch_mask) && !overflow && !underflow);

  assert_step_pc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid && issue_en && !is_branch && !launch |=>
      top_pc == $past(top_pc) + PCW'(PC_INC) && stack_depth == $past(stack_depth));

  assert_uniform_taken_R3: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid && issue_en && is_branch && !launch && ((br_taken & top_mask) == top_mask) |=>
      top_pc == $past(br_target) && stack_depth == $past(stack_depth));

  assert_pop_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_en && !launch |=> stack_depth == $past(stack_depth) - DW'(1));

  assert_stall_needs_depth_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_en |-> stack_depth > DW'(1));

  assert_depth_bounds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stack_depth >= DW'(1) && int'(stack_depth) <= DEPTH);

  assert_overflow_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    overflow && !launch |=> overflow);

  assert_underflow_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    underflow && !launch |=> underflow && stack_depth == DW'(1));
endmodule

bind simt_reconv_stack simt_reconv_stack_chk #(
  .WARP(WARP), .DEPTH(DEPTH), .PCW(PCW), .PC_INC(PC_INC)
) u_chk (.*);

// File: tb/simt_reconv_stack_tb.sv
`timescale 1ns/1ps
module simt_reconv_stack_tb;
  localparam int W = 4, D = 4, P = 8, DW = $clog2(D + 1);

  logic clk = 0, rst_n = 0, launch = 0, instr_valid = 0, is_branch = 0;
  logic [P-1:0] launch_pc = 0, br_target = 0, br_fallthru = 0, br_rpc = 0;
  logic [W-1:0] launch_mask = 0, br_taken = 0;
  logic [P-1:0] top_pc;
  logic [W-1:0] top_mask;
  logic issue_en, overflow, underflow;
  logic [DW-1:0] stack_depth;
  int checks = 0, fails = 0, cyc = 0;

  always #5 clk = ~clk;

  simt_reconv_stack #(.WARP(W), .DEPTH(D), .PCW(P), .PC_INC(1)) u_dut (.*);

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: act=%0d cycles exp<150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic op(bit br, logic [P-1:0] tg, logic [P-1:0] ft, logic [P-1:0] rp, logic [W-1:0] tm);
    instr_valid = 1; is_branch = br; br_target = tg; br_fallthru = ft; br_rpc = rp; br_taken = tm;
    tick();
    instr_valid = 0; is_branch = 0;
  endtask

  task automatic start(logic [P-1:0] pc, logic [W-1:0] m);
    launch = 1; launch_pc = pc; launch_mask = m;
    tick();
    launch = 0;
  endtask

  initial begin
    logic [W-1:0] tk, nt;
    repeat (2) tick();
    rst_n = 1;
    chk("R1 reset depth", int'(stack_depth), 1);
    chk("R1 reset pc", int'(top_pc), 0);
    chk("R1 reset mask", int'(top_mask), 'hF);
    chk("R1 reset flags", int'({overflow, underflow}), 0);
    chk("R1 reset issue", int'(issue_en), 1);

    for (int lm = 0; lm < 16; lm++) begin
      for (int tm = 0; tm < 16; tm++) begin
        start(8'h00, W'(lm));
        chk("R1 launch depth", int'(stack_depth), 1);
        chk("R1 launch mask", int'(top_mask), lm);
        tk = W'(tm & lm);
        nt = W'(lm & ~tm);
        op(1, 8'h20, 8'h10, 8'h30, W'(tm));
        if (nt == 0) begin
          chk("R3 R10 uniform taken pc", int'(top_pc), 'h20);
          chk("R3 uniform taken depth", int'(stack_depth), 1);
        end else if (tk == 0) begin
          chk("R3 R10 uniform fallthru pc", int'(top_pc), 'h10);
          chk("R3 uniform fallthru depth", int'(stack_depth), 1);
        end else begin
          chk("R4 split depth", int'(stack_depth), 3);
          chk("R4 taken first pc", int'(top_pc), 'h20);
          chk("R4 R10 taken mask", int'(top_mask), int'(tk));
          repeat (16) op(0, 0, 0, 0, 0);
          chk("R6 stall at rpc", int'(issue_en), 0);
          op(0, 0, 0, 0, 0);
          chk("R6 popped depth", int'(stack_depth), 2);
          chk("R6 R4 nt pc unchanged", int'(top_pc), 'h10);
          chk("R4 R10 nt mask", int'(top_mask), int'(nt));
          repeat (32) op(0, 0, 0, 0, 0);
          chk("R6 stall nt at rpc", int'(issue_en), 0);
          tick();
          chk("R4 reconverged depth", int'(stack_depth), 1);
          chk("R4 reconverged pc", int'(top_pc), 'h30);
          chk("R4 reconverged mask", int'(top_mask), lm);
          chk("R6 issue resumes", int'(issue_en), 1);
        end
        op(0, 0, 0, 0, 0);
        chk("R2 step pc", int'(top_pc), (nt == 0) ? 'h21 : (tk == 0) ? 'h11 : 'h31);
      end
    end

    start(8'h40, 4'hF);
    op(1, 8'h40, 8'h50, 8'h50, 4'b0011);
    chk("R5 loop one push depth", int'(stack_depth), 2);
    chk("R5 loop header pc", int'(top_pc), 'h40);
    chk("R5 loop mask", int'(top_mask), 'b0011);
    op(1, 8'h40, 8'h50, 8'h50, 4'b0001);
    chk("R5 nested loop depth", int'(stack_depth), 3);
    chk("R5 nested loop mask", int'(top_mask), 'b0001);
    op(1, 8'h40, 8'h50, 8'h50, 4'b0000);
    chk("R3 exit pc", int'(top_pc), 'h50);
    chk("R7 first pop stall", int'(issue_en), 0);
    tick();
    chk("R7 first pop depth", int'(stack_depth), 2);
    chk("R7 chained stall", int'(issue_en), 0);
    tick();
    chk("R7 chained depth", int'(stack_depth), 1);
    chk("R7 chained mask", int'(top_mask), 'hF);
    chk("R7 chained pc", int'(top_pc), 'h50);

    start(8'h00, 4'hF);
    op(1, 8'h20, 8'h10, 8'h30, 4'b1100);
    op(1, 8'h28, 8'h24, 8'h2C, 4'b0100);
    chk("R8 overflow flag", int'(overflow), 1);
    chk("R8 overflow depth", int'(stack_depth), 3);
    chk("R8 overflow pc", int'(top_pc), 'h20);
    chk("R8 overflow mask", int'(top_mask), 'b1100);
    op(1, 8'h28, 8'h2C, 8'h2C, 4'b0100);
    chk("R8 fitting push depth", int'(stack_depth), 4);
    chk("R8 flag sticky", int'(overflow), 1);
    start(8'h00, 4'hF);
    chk("R1 launch clears overflow", int'(overflow), 0);

    start(8'hFC, 4'hF);
    repeat (3) op(0, 0, 0, 0, 0);
    chk("R9 at sentinel pc", int'(top_pc), 'hFF);
    tick();
    chk("R9 underflow flag", int'(underflow), 1);
    chk("R9 depth kept", int'(stack_depth), 1);
    chk("R9 issue kept", int'(issue_en), 1);
    start(8'h00, 4'hF);
    chk("R1 launch clears underflow", int'(underflow), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule